// File: doc/BRIEF.md
# Unary Bit-Stream Adder

This block adds two deterministic unary bit-streams. An operand is carried as N serial bits of equal weight, and its value is the number of ones divided by N. The position of the ones within the stream does not affect the value. A `start` pulse opens an operation while the block is idle. The block then takes one bit from each operand on every cycle in which `in_valid` is high, until it has taken N pairs. It returns a serial result on `out_bit`/`out_valid` and raises `done` for one cycle when the result is complete.

The `EXACT` parameter selects one of two variants at elaboration. The exact variant lengthens the result to 2N bits and loses nothing: it emits the N bits of operand A as they arrive, then replays the N stored bits of operand B. The halving variant keeps the result at N bits so that it can drive another stage of the same width. It carries a one-bit half-unit credit between cycles and emits a one whenever the credit and the two incoming bits together reach two half-units. The halved sum is rounded down, so the error is never more than 1/(2N).

Top module: `ubs_adder`

## Requirements
- R1: After reset, `out_valid` and `done` are low and the block is idle.
- R2: A `start` sampled while idle begins an operation. `in_valid` is ignored while idle and in the cycle that `start` is taken.
- R3: With `EXACT`=1 the result has exactly 2N bits. Result bit k is A bit k for k < N, and B bit k-N for the rest, with bits numbered in arrival order.
- R4: With `EXACT`=1 the number of ones in the result equals popcount(A) + popcount(B), whatever the order of the ones.
- R5: With `EXACT`=0 the result has exactly N bits, and its ones count is floor((popcount(A)+popcount(B))/2) for any order of the ones.
- R6: Each accepted input pair produces one result bit with `out_valid` high on the next cycle. With `EXACT`=1 the N replayed B bits follow back to back.
- R7: `done` is high for exactly one cycle, in the cycle right after the final result bit.
- R8: A `start` that arrives while an operation is running has no effect on that operation's result.
- R9: While operands are being collected, a cycle with `in_valid` low produces no result bit on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when idle |
| in_valid | input | 1 | An operand bit pair is present |
| a_bit | input | 1 | Current bit of operand A |
| b_bit | input | 1 | Current bit of operand B |
| out_bit | output | 1 | Current result bit |
| out_valid | output | 1 | `out_bit` holds a result bit |
| done | output | 1 | One-cycle pulse after the last result bit |

## Verification
Adversarial orderings place every one of A at the end of its stream and every one of B at the start. These orderings catch a halving variant that flushes its credit too early or drops it between operands. Odd totals check that the leftover half-unit rounds down, because a design that rounds up or loses the credit misses by one. A start pulse in the middle of an operation checks R8: a block that restarts on it emits a short or corrupted result. Random idle gaps between operand pairs check R9: a design that counts cycles instead of pairs emits spurious result bits or ends early.

// File: rtl/ubs_adder.sv
module ubs_adder #(
  parameter int N = 32,
  parameter bit EXACT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic a_bit,
  input  logic b_bit,
  output logic out_bit,
  output logic out_valid,
  output logic done
);
  localparam int CW = $clog2(N + 1);
  localparam int OUT_LEN = EXACT ? 2 * N : N;

  logic          busy, fed, last_q, credit;
  logic [CW-1:0] cnt;
  logic [N-1:0]  bbuf;

  wire       take = busy && !fed && !last_q && in_valid;
  wire [1:0] csum = {1'b0, credit} + {1'b0, a_bit} + {1'b0, b_bit};
  wire       emit = csum[1];
  wire       end_cnt = (cnt == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fed <= 1'b0; last_q <= 1'b0; credit <= 1'b0;
      cnt <= '0; bbuf <= '0;
      out_bit <= 1'b0; out_valid <= 1'b0; done <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      last_q <= 1'b0;
      done <= last_q;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; fed <= 1'b0; cnt <= '0; credit <= 1'b0;
        end
      end else if (last_q) begin
        busy <= 1'b0;
      end else if (take) begin
        out_valid <= 1'b1;
        out_bit <= EXACT ? a_bit : emit;
        credit <= csum[0];
        bbuf <= {b_bit, bbuf[N-1:1]};
        cnt <= end_cnt ? '0 : cnt + 1'b1;
        if (end_cnt) begin
          fed <= 1'b1;
          if (!EXACT) last_q <= 1'b1;
        end
      end else if (fed && EXACT) begin
        out_valid <= 1'b1;
        out_bit <= bbuf[0];
        bbuf <= {1'b0, bbuf[N-1:1]};
        cnt <= cnt + 1'b1;
        if (end_cnt) last_q <= 1'b1;
      end
    end
  end

  logic [CW:0] ocnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ocnt <= '0;
    else if (!busy) ocnt <= '0;
    else if (out_valid) ocnt <= ocnt + 1'b1;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid));
  a_r3_r5_length: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ocnt == (CW+1)'(OUT_LEN));
  a_r6_valid_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  a_r9_no_out_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fed && !last_q && !in_valid) |=> !out_valid);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_q) |=> busy);
endmodule

// File: tb/test_ubs_adder.sv
module test_ubs_adder;
  localparam int N = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, a_bit = 1'b0, b_bit = 1'b0;
  logic ex_bit, ex_valid, ex_done, hf_bit, hf_valid, hf_done;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ubs_adder #(.N(N), .EXACT(1'b1)) i_ubs_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .a_bit(a_bit), .b_bit(b_bit),
    .out_bit(ex_bit), .out_valid(ex_valid), .done(ex_done));
  ubs_adder #(.N(N), .EXACT(1'b0)) i_ubs_adder_half (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .a_bit(a_bit), .b_bit(b_bit),
    .out_bit(hf_bit), .out_valid(hf_valid), .done(hf_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  logic [2*N-1:0] ex_seq;
  int ex_n, ex_ones, hf_n, hf_ones, ex_dn, hf_dn;
  logic prev_ex_v = 1'b0, prev_hf_v = 1'b0;

  always @(negedge clk) begin
    if (ex_valid) begin
      if (ex_n < 2 * N) ex_seq[ex_n] = ex_bit;
      ex_n++; ex_ones += int'(ex_bit);
    end
    if (hf_valid) begin
      hf_n++; hf_ones += int'(hf_bit);
    end
    if (ex_done) begin
      ex_dn++;
      check(prev_ex_v && ex_n == 2 * N, "R7 exact done timing", ex_n, 2 * N);
    end
    if (hf_done) begin
      hf_dn++;
      check(prev_hf_v && hf_n == N, "R7 half done timing", hf_n, N);
    end
    prev_ex_v = ex_valid;
    prev_hf_v = hf_valid;
  end

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input int gap_pct, input bit mid_start);
    int pa, pb, waitc;
    pa = popc(a); pb = popc(b);
    ex_n = 0; ex_ones = 0; hf_n = 0; hf_ones = 0; ex_dn = 0; hf_dn = 0; ex_seq = '0;
    start = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1; start = 1'b0;
    for (int i = 0; i < N; i++) begin
      while (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
        check(!ex_valid && !hf_valid, "R9 gap", int'(ex_valid) + int'(hf_valid), 0);
      end
      in_valid = 1'b1; a_bit = a[i]; b_bit = b[i];
      start = mid_start && (i == N / 2);
      @(posedge clk); #1;
      start = 1'b0;
      if (i == 0 || i == N - 1)
        check(ex_valid && hf_valid && ex_bit == a[i], "R6 output follows input",
              int'(ex_valid) + int'(hf_valid), 2);
    end
    in_valid = 1'b0;
    waitc = 0;
    while (ex_dn == 0 && waitc < 3 * N) begin
      @(posedge clk); #1; waitc++;
    end
    @(posedge clk); #1;
    check(ex_n == 2 * N, "R3 exact length", ex_n, 2 * N);
    check(ex_seq == {b, a}, "R3 exact order", int'(ex_seq != {b, a}), 0);
    check(ex_ones == pa + pb, "R4 exact ones", ex_ones, pa + pb);
    check(hf_n == N, "R5 half length", hf_n, N);
    check(hf_ones == (pa + pb) / 2, "R5 half ones", hf_ones, (pa + pb) / 2);
    check(ex_dn == 1 && hf_dn == 1, "R7 single done", ex_dn * 10 + hf_dn, 11);
    if (mid_start) check(ex_n == 2 * N && hf_n == N, "R8 start ignored", hf_n, N);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] ra, rb;
    void'($urandom(32'd1234));
    #1;
    check(!ex_valid && !ex_done && !hf_valid && !hf_done, "R1 reset outputs",
          int'(ex_valid) + int'(ex_done) + int'(hf_valid) + int'(hf_done), 0);
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    in_valid = 1'b1; a_bit = 1'b1; b_bit = 1'b1;
    repeat (3) begin
      @(posedge clk); #1;
      check(!ex_valid && !hf_valid, "R2 idle in_valid ignored",
            int'(ex_valid) + int'(hf_valid), 0);
    end
    in_valid = 1'b0;
    run_op('0, '0, 0, 1'b0);
    run_op('1, '1, 0, 1'b0);
    run_op('1, '0, 0, 1'b0);
    run_op({(N/2){2'b01}}, {(N/2){2'b10}}, 0, 1'b0);
    run_op({{(N/2){1'b1}}, {(N/2){1'b0}}}, {{(N/2){1'b0}}, {(N/2){1'b1}}}, 0, 1'b0);
    run_op({1'b1, {(N-1){1'b0}}}, '0, 0, 1'b0);
    run_op('0, {{(N-1){1'b0}}, 1'b1}, 30, 1'b0);
    run_op({N{1'b1}}, {1'b1, {(N-1){1'b0}}}, 0, 1'b1);
    for (int k = 0; k < 12; k++) begin
      ra = N'({$urandom, $urandom});
      rb = N'({$urandom, $urandom});
      run_op(ra, rb, (k % 3) * 20, k == 5);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule